// File: doc/BRIEF.md
# Serial Channel Programmer

This block is a three-wire serial slave that sets up a bank of twelve 10-bit channel codes and a clock-source flag. A host lowers an active-low frame enable, shifts 16-bit command words in on the rising edges of a serial clock, and then raises the enable. When the enable rises, the last sixteen bits captured are decoded. A valid word writes its 10-bit value into the channel it addresses and sets the clock-source flag. The block then pulses a write strobe for one cycle.

The shift register's most significant bit is passed out on a serial output, which changes on falling serial-clock edges. Several devices can therefore share one port. Their enables and serial clocks are tied together, and each serial output feeds the next device's serial input. All devices in the chain commit together when the shared enable rises. The serial pins are sampled on the system clock, so serial-clock edges are detected at system-clock resolution. The serial pins are expected to be already synchronous to that clock.

Top module: `serial_chan_prog`

## Requirements
- R1: While reset is asserted, and after it is released, all channel codes read 0, the clock-source flag reads 0 (internal), the serial output reads 0 and the write strobe is low.
- R2: While the enable is low, each rising serial-clock edge shifts the serial input into a 16-bit register, most significant bit first. When the enable rises, a valid word writes bits 9..0 into the channel whose number is held in bits 13..10. That channel's code is readable on the output one system-clock cycle after the rising enable is sampled.
- R3: A valid word copies its bit 14 to the clock-source flag, where 1 selects the external source and 0 the internal source. No other event changes this flag.
- R4: A word with bit 15 set changes no channel code and does not change the clock-source flag.
- R5: A word whose address in bits 13..10 is 12, 13, 14 or 15 changes no channel code and does not change the clock-source flag.
- R6: A frame with fewer than 16 rising serial-clock edges is discarded: nothing is written and no strobe is produced.
- R7: If a frame has more than 16 rising serial-clock edges, only the last 16 bits shifted are decoded.
- R8: Serial-clock edges seen while the enable is high shift nothing and do not change the serial output.
- R9: The serial output changes only on falling serial-clock edges while the enable is low. A bit shifted in on rising edge k appears on the serial output after falling edge k+15, which is the 16th falling edge counted from edge k.
- R10: The write strobe is high for exactly one system-clock cycle for each valid word committed, and it is never high while the enable is low.
- R11: A write changes only the addressed channel. All other channel codes keep their values.
- R12: In a chain of two devices fed with 32 bits in one frame, the first word shifted lands in the downstream device, the second lands in the upstream device, and both commit on the same rising enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| enaN | input | 1 | Active-low frame enable |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial pass-through output for chaining |
| chanVals | output | NUM_CH*DATA_W (120) | Channel codes, with channel n at bits n*DATA_W upward |
| oscExt | output | 1 | Clock-source flag: 1 external, 0 internal |
| wrStrobe | output | 1 | One-cycle pulse on each valid write |

## Verification
The bench builds the block with its default twelve channels, 10-bit codes and 4-bit address. This keeps the address space small enough to sweep completely: every one of the sixteen address codes is tried with both clock-source values, so the valid range and the four out-of-range addresses are all exercised. The serial output is checked after every falling edge from the 16th onward in every full-length frame. A second instance chained to the first shows the two-device word order and the simultaneous commit.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef struct packed {
    logic shiftEn;
    logic sdoEn;
    logic commit;
  } progCtrl_t;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enaN,
  input  logic      sclk,
  output progCtrl_t ctrl
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic             sclkQ;
  logic             enaQ;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkRise;

  assign sclkRise = !enaN && sclk && !sclkQ;

  always_comb begin
    ctrl.shiftEn = sclkRise;
    ctrl.sdoEn   = !enaN && !sclk && sclkQ;
    ctrl.commit  = enaN && !enaQ && (bitCnt == FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      enaQ   <= 1'b1;
      bitCnt <= '0;
    end else begin
      sclkQ <= sclk;
      enaQ  <= enaN;
      if (!enaN && enaQ) begin
        bitCnt <= '0;
      end else if (sclkRise && bitCnt != FULL) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdi,
  input  progCtrl_t                ctrl,
  output logic                     sdo,
  output logic [NUM_CH*DATA_W-1:0] chanFlat,
  output logic                     oscExt,
  output logic                     wrStrobe
);
  localparam int WORD_W = DATA_W + ADDR_W + 2;

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic              wordOk;

  assign addr   = shiftReg[DATA_W +: ADDR_W];
  assign data   = shiftReg[DATA_W-1:0];
  assign wordOk = ctrl.commit && !shiftReg[WORD_W-1] && (int'(addr) < NUM_CH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdo      <= 1'b0;
      oscExt   <= 1'b0;
      wrStrobe <= 1'b0;
    end else begin
      if (ctrl.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], sdi};
      if (ctrl.sdoEn)   sdo      <= shiftReg[WORD_W-1];
      if (wordOk)       oscExt   <= shiftReg[WORD_W-2];
      wrStrobe <= wordOk;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [DATA_W-1:0] chanReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanReg <= '0;
      end else if (wordOk && addr == ADDR_W'(g)) begin
        chanReg <= data;
      end
    end
    assign chanFlat[g*DATA_W +: DATA_W] = chanReg;
  end
endmodule

// File: rtl/serial_chan_prog.sv
module serial_chan_prog
  import spc_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enaN,
  input  logic                     sclk,
  input  logic                     sdi,
  output logic                     sdo,
  output logic [NUM_CH*DATA_W-1:0] chanVals,
  output logic                     oscExt,
  output logic                     wrStrobe
);
  localparam int WORD_W = DATA_W + ADDR_W + 2;

  progCtrl_t ctrl;

  spc_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .enaN (enaN),
    .sclk (sclk),
    .ctrl (ctrl)
  );

  spc_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdi      (sdi),
    .ctrl     (ctrl),
    .sdo      (sdo),
    .chanFlat (chanVals),
    .oscExt   (oscExt),
    .wrStrobe (wrStrobe)
  );
endmodule

// File: rtl/serial_chan_prog_chk.sv
module serial_chan_prog_chk #(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 10
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     enaN,
  input logic                     sdo,
  input logic [NUM_CH*DATA_W-1:0] chanVals,
  input logic                     oscExt,
  input logic                     wrStrobe
);
  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R10
  strobe_ena_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> enaN);

  // R8
  sdo_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    enaN |=> $stable(sdo));

  // R11
  chan_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanVals) |-> wrStrobe);

  // R3
  osc_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oscExt) |-> wrStrobe);
endmodule

bind serial_chan_prog serial_chan_prog_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enaN     (enaN),
  .sdo      (sdo),
  .chanVals (chanVals),
  .oscExt   (oscExt),
  .wrStrobe (wrStrobe)
);

// File: tb/test_serial_chan_prog.sv
`timescale 1ns/1ps
module test_serial_chan_prog;
  localparam int NUM_CH = 12;
  localparam int DATA_W = 10;
  localparam int FW = NUM_CH * DATA_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enaN = 1'b1;
  logic enaNB = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdoB, oscExt, oscB, wrStrobe, wrB;
  logic [FW-1:0] chanVals, chanB;

  int checks = 0;
  int fails = 0;
  int strobeCnt = 0;
  logic [DATA_W-1:0] expCh [NUM_CH];
  logic [DATA_W-1:0] expChB [NUM_CH];
  logic expOsc = 1'b0;
  logic expOscB = 1'b0;

  always #5 clk = ~clk;

  serial_chan_prog i_serial_chan_prog (
    .clk(clk), .rstN(rstN), .enaN(enaN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .chanVals(chanVals), .oscExt(oscExt), .wrStrobe(wrStrobe)
  );

  serial_chan_prog i_serial_chan_prog_b (
    .clk(clk), .rstN(rstN), .enaN(enaNB), .sclk(sclk), .sdi(sdo), .sdo(sdoB),
    .chanVals(chanB), .oscExt(oscB), .wrStrobe(wrB)
  );

  always @(negedge clk) if (wrStrobe) strobeCnt++;

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] flatA();
    logic [FW-1:0] f;
    for (int i = 0; i < NUM_CH; i++) f[i*DATA_W +: DATA_W] = expCh[i];
    return f;
  endfunction

  function automatic logic [FW-1:0] flatB();
    logic [FW-1:0] f;
    for (int i = 0; i < NUM_CH; i++) f[i*DATA_W +: DATA_W] = expChB[i];
    return f;
  endfunction

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Returns 1 when the word is a valid write.
  function automatic bit modelA(input logic [15:0] w);
    if (!w[15] && w[13:10] < 12) begin
      expCh[w[13:10]] = w[9:0];
      expOsc = w[14];
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // Shifts n bits, msb first; checks sdo from the 16th falling edge (R9).
  task automatic frame(input logic [63:0] bits, input int n, input bit chain);
    enaN = 1'b0;
    if (chain) enaNB = 1'b0;
    waitClk(2);
    for (int k = 1; k <= n; k++) begin
      sdi = bits[n-k];
      waitClk(2);
      sclk = 1'b1;
      waitClk(2);
      sclk = 1'b0;
      waitClk(2);
      if (k >= 16) chk("R9 sdo after falling edge", FW'(sdo), FW'(bits[n-1-(k-16)]));
    end
    waitClk(1);
    enaN = 1'b1;
    enaNB = 1'b1;
    waitClk(3);
  endtask

  task automatic wordTest(input logic [15:0] w, input string req);
    int s0;
    bit ok;
    s0 = strobeCnt;
    ok = modelA(w);
    frame({48'b0, w}, 16, 1'b0);
    chk(req, chanVals, flatA());
    chk({req, " osc flag"}, FW'(oscExt), FW'(expOsc));
    chk("R10 strobe count", FW'(strobeCnt - s0), FW'(ok ? 1 : 0));
  endtask

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin
      expCh[i] = '0;
      expChB[i] = '0;
    end
    waitClk(3);
    // R1 during reset
    chk("R1 channels in reset", chanVals, '0);
    chk("R1 osc in reset", FW'(oscExt), '0);
    chk("R1 sdo/strobe in reset", FW'({sdo, wrStrobe}), '0);
    rstN = 1'b1;
    waitClk(2);
    chk("R1 channels after reset", chanVals, '0);
    chk("R1 osc after reset", FW'(oscExt), '0);

    // R2 R3 R5 R11: full address sweep with both clock-source values
    for (int a = 0; a < 16; a++) begin
      for (int o = 0; o < 2; o++) begin
        logic [9:0] d;
        d = 10'((a * 83 + o * 517 + 29) % 1024);
        wordTest({1'b0, o[0], a[3:0], d}, (a < 12) ? "R2 R11 write" : "R5 bad address");
      end
    end
    // R2 code extremes
    wordTest({1'b0, 1'b0, 4'd0, 10'd1023}, "R2 max code");
    wordTest({1'b0, 1'b1, 4'd11, 10'd0}, "R2 zero code");
    // R4 top bit set
    wordTest({1'b1, 1'b0, 4'd3, 10'h155}, "R4 top bit set");
    wordTest({1'b1, 1'b1, 4'd0, 10'h2AA}, "R4 top bit set osc");

    // R6 short frame
    begin
      int s0;
      s0 = strobeCnt;
      frame({49'b0, 15'h1234}, 15, 1'b0);
      chk("R6 short frame channels", chanVals, flatA());
      chk("R6 short frame strobe", FW'(strobeCnt - s0), '0);
    end

    // R7 long frame: 4 leading junk bits, then a valid word
    begin
      int s0;
      logic [15:0] w;
      w = {1'b0, 1'b0, 4'd5, 10'd777};
      s0 = strobeCnt;
      void'(modelA(w));
      frame({44'b0, 4'hF, w}, 20, 1'b0);
      chk("R7 long frame channels", chanVals, flatA());
      chk("R7 long frame strobe", FW'(strobeCnt - s0), FW'(1));
    end

    // R8 serial clock toggled while enable high
    begin
      logic sdoBefore;
      int s0;
      sdoBefore = sdo;
      s0 = strobeCnt;
      for (int k = 0; k < 20; k++) begin
        sdi = k[0];
        waitClk(2);
        sclk = 1'b1;
        waitClk(2);
        sclk = 0;
        waitClk(2);
        chk("R8 sdo idle", FW'(sdo), FW'(sdoBefore));
      end
      chk("R8 channels idle", chanVals, flatA());
      chk("R8 strobe idle", FW'(strobeCnt - s0), '0);
      // a 16-bit frame after idle toggling decodes only its own bits
      wordTest({1'b0, 1'b1, 4'd7, 10'd31}, "R8 R2 frame after idle clocks");
    end

    // R12 chain of two devices
    begin
      logic [15:0] wB, wA;
      wB = {1'b0, 1'b1, 4'd9, 10'd600};
      wA = {1'b0, 1'b0, 4'd2, 10'd45};
      void'(modelA(wA));
      expChB[9] = 10'd600;
      expOscB = 1'b1;
      frame({32'b0, wB, wA}, 32, 1'b1);
      chk("R12 downstream channels", chanB, flatB());
      chk("R12 downstream osc", FW'(oscB), FW'(expOscB));
      chk("R12 upstream channels", chanVals, flatA());
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule